// File: doc/BRIEF.md
# SPI Master Receive Channel with Overlapped Receive

This block is a single-slave SPI master channel. It moves words of 4 to 32 bits over SCLK, MOSI and MISO, with an active-low chip select. Three transfer modes are offered: full duplex (transmit-receive), receive-only and transmit-only. The host side is a set of plain configuration inputs (enable, mode, turbo, word length, clock divider), a one-word transmit holding register with an empty flag, a one-word receive holding register with a full flag, and an end-of-transfer flag.

In receive-only mode the channel produces the clocks itself. Without turbo, one word is clocked when the channel is enabled with an empty receive holding register, and each host read of that register lets the next word go. The host drops enable before reading the final word, so that no extra word is clocked.

With turbo set in receive-only mode, the shift register may clock the next word while the holding register is still full. That word then waits in the shift register, with SCLK stopped, until the host reads. The host drops enable once the penultimate word is in the holding register. The word already in flight still completes and lands in the holding register.

Top module: `spi_rx_chan`

## Requirements
- R1: After reset, cs_n is 1, sclk is 0, mosi is 0, rx_full is 0, tx_empty is 1 and eot is 1.
- R2: In transmit-receive mode (cfg_mode 2'b00, 2'b11 behaves the same), a word starts only when the channel is enabled, the transmit register holds a word and rx_full is 0. The word is sent MSB first on MOSI and captured from MISO. The captured word is loaded into the receive register and sets rx_full.
- R3: In receive-only mode (cfg_mode 2'b01) without turbo, a word starts when the channel is enabled and rx_full is 0, so each host read lets exactly one more word go. If enable is cleared before the final read, no further word is clocked.
- R4: In receive-only mode with cfg_turbo 1, the next word is clocked while rx_full is 1. A read then moves that completed word into the receive register in the same cycle, and rx_full stays 1.
- R5: Clearing enable while a word is in flight lets that word finish and land in the receive register. No new word starts after it.
- R6: When both the shift register and the receive register hold unread words, SCLK stays low until the host reads, and no received word is lost or overwritten.
- R7: The turbo bit has no effect in transmit-receive or transmit-only mode. In transmit-receive mode, a full receive register blocks the next word even with turbo set.
- R8: In transmit-only mode (cfg_mode 2'b10), received bits are discarded and rx_full stays 0.
- R9: cfg_wlen holds the word length minus one; values below 3 are treated as 3. Received data is right-aligned in rx_data, and the bits above the word are 0. Exactly that many SCLK pulses are produced per word.
- R10: SCLK idles low. Its period is 2^N system clocks, where N is cfg_div, and cfg_div 0 is treated as 1. MISO is sampled on the rising edge and MOSI changes on the falling edge.
- R11: In receive-only mode MOSI stays low.
- R12: cs_n is low while the channel is enabled or a word is in flight. Once enable is low, cs_n rises 2^N system clocks after the final falling SCLK edge.
- R13: eot is 1 exactly when the shift register is idle, no completed word is waiting in it, and, in the two transmitting modes, the transmit register is empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_en | input | 1 | Channel enable |
| cfg_mode | input | 2 | 00 transmit-receive, 01 receive-only, 10 transmit-only, 11 as 00 |
| cfg_turbo | input | 1 | Overlapped receive; acts only in receive-only mode |
| cfg_wlen | input | $clog2(WMAX) | Word length minus one (3 to WMAX-1) |
| cfg_div | input | DIVW | SCLK divider exponent N; period 2^N clocks |
| tx_wr | input | 1 | Write strobe for the transmit register |
| tx_data | input | WMAX | Transmit word, right-aligned |
| tx_empty | output | 1 | Transmit register can take a word |
| rx_rd | input | 1 | Read strobe for the receive register |
| rx_data | output | WMAX | Received word, right-aligned |
| rx_full | output | 1 | Receive register holds an unread word |
| eot | output | 1 | End of transfer |
| sclk | output | 1 | SPI clock, mode 0 |
| mosi | output | 1 | Master data out |
| miso | input | 1 | Master data in |
| cs_n | output | 1 | Active-low chip select |

## Verification
The bench targets the end of a turbo burst: enable is dropped after the penultimate word arrives. A design that aborted the word in flight would come up one word short, and one that kept going would clock a fifth word into an empty slave. It also leaves both the shift and receive registers full for a long time: a design that kept shifting would either overwrite data or produce extra SCLK pulses, and either shows up in the pulse count and the scoreboard. The non-turbo receive case is checked for a held-back start while the receive register is full, and transmit-receive is checked with the turbo bit set, where a design that honoured the bit would start a second word early. The clamped and extreme word lengths and the divider-0 case catch off-by-one errors in the bit count, the alignment and the SCLK period.

// File: rtl/spi_rx_chan.sv
module spi_rx_chan #(
  parameter int WMAX = 32,
  parameter int DIVW = 4
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    cfg_en,
  input  logic [1:0]              cfg_mode,
  input  logic                    cfg_turbo,
  input  logic [$clog2(WMAX)-1:0] cfg_wlen,
  input  logic [DIVW-1:0]         cfg_div,
  input  logic                    tx_wr,
  input  logic [WMAX-1:0]         tx_data,
  output logic                    tx_empty,
  input  logic                    rx_rd,
  output logic [WMAX-1:0]         rx_data,
  output logic                    rx_full,
  output logic                    eot,
  output logic                    sclk,
  output logic                    mosi,
  input  logic                    miso,
  output logic                    cs_n
);
  localparam int LW = $clog2(WMAX);
  localparam int BW = $clog2(WMAX + 1);
  localparam int CW = (1 << DIVW) + 1;
  localparam logic [1:0] M_TXRX = 2'b00;
  localparam logic [1:0] M_RX   = 2'b01;
  localparam logic [1:0] M_TX   = 2'b10;

  function automatic logic [WMAX-1:0] low_mask(input logic [LW-1:0] w);
    logic [WMAX-1:0] ones;
    ones = '1;
    return ones >> (LW'(WMAX - 1) - w);
  endfunction

  logic            busy, sclk_q, mosi_q, cap_q, pend;
  logic [WMAX-1:0] sh, tx_hold, rx_hold;
  logic [BW-1:0]   bitc;
  logic [CW-1:0]   hc, tail;
  logic [LW-1:0]   wl_q;
  logic            tx_empty_q, rx_full_q;

  wire is_rx    = (cfg_mode == M_RX);
  wire is_tx    = (cfg_mode == M_TX);
  wire turbo_on = cfg_turbo && is_rx;

  wire [DIVW-1:0] n_eff  = (cfg_div == '0) ? DIVW'(1) : cfg_div;
  wire [CW-1:0]   period = CW'(1) << n_eff;
  wire [CW-1:0]   half   = period >> 1;
  wire [LW-1:0]   wl_eff = (cfg_wlen < LW'(3)) ? LW'(3) : cfg_wlen;

  wire start = cfg_en && !busy && !pend &&
               (is_rx ? (turbo_on || !rx_full_q)
                      : (!tx_empty_q && (is_tx || !rx_full_q)));
  wire edge_now = busy && (hc == '0);
  wire done     = edge_now && sclk_q && (bitc == BW'(wl_q) + BW'(1));
  wire hold_free = !rx_full_q || rx_rd;
  wire [WMAX-1:0] rx_word = sh & low_mask(wl_q);

  // shift engine
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy   <= 1'b0;
      sclk_q <= 1'b0;
      mosi_q <= 1'b0;
      cap_q  <= 1'b0;
      sh     <= '0;
      bitc   <= '0;
      hc     <= '0;
      wl_q   <= LW'(3);
    end else if (start) begin
      busy   <= 1'b1;
      sclk_q <= 1'b0;
      hc     <= half - CW'(1);
      bitc   <= '0;
      wl_q   <= wl_eff;
      cap_q  <= !is_tx;
      sh     <= is_rx ? '0 : tx_hold;
      mosi_q <= is_rx ? 1'b0 : tx_hold[wl_eff];
    end else if (busy) begin
      if (hc != '0) begin
        hc <= hc - CW'(1);
      end else begin
        hc <= half - CW'(1);
        if (!sclk_q) begin
          sclk_q <= 1'b1;
          sh     <= {sh[WMAX-2:0], miso};
          bitc   <= bitc + BW'(1);
        end else begin
          sclk_q <= 1'b0;
          if (done) begin
            busy   <= 1'b0;
            mosi_q <= 1'b0;
          end else begin
            mosi_q <= sh[wl_q];
          end
        end
      end
    end
  end

  // transmit holding register
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_hold    <= '0;
      tx_empty_q <= 1'b1;
    end else if (tx_wr) begin
      tx_hold    <= tx_data;
      tx_empty_q <= 1'b0;
    end else if (start && !is_rx) begin
      tx_empty_q <= 1'b1;
    end
  end

  // receive holding register and pending word
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_hold   <= '0;
      rx_full_q <= 1'b0;
      pend      <= 1'b0;
    end else if (done && cap_q) begin
      if (hold_free) begin
        rx_hold   <= rx_word;
        rx_full_q <= 1'b1;
      end else begin
        pend <= 1'b1;
      end
    end else if (rx_rd && rx_full_q) begin
      if (pend) begin
        rx_hold <= rx_word;
        pend    <= 1'b0;
      end else begin
        rx_full_q <= 1'b0;
      end
    end
  end

  // chip select tail
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                tail <= '0;
    else if (cfg_en || busy)   tail <= period;
    else if (tail != '0)       tail <= tail - CW'(1);
  end

  assign sclk     = sclk_q;
  assign mosi     = mosi_q;
  assign tx_empty = tx_empty_q;
  assign rx_full  = rx_full_q;
  assign rx_data  = rx_hold;
  assign cs_n     = !(cfg_en || busy || (tail != '0));
  assign eot      = !busy && !pend && (is_rx || tx_empty_q);

  AST_RX_MOSI_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && is_rx) |-> !mosi_q); // R11
  AST_HOLD_WHEN_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && is_rx && !turbo_on && rx_full_q) |=> !busy); // R3
  AST_PEND_KEEPS_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    (pend && rx_rd) |=> rx_full_q); // R4
  AST_LANDS_ON_FINISH: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(busy) && cap_q) |-> (rx_full_q || pend)); // R5
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    pend |-> rx_full_q); // R6
  AST_STALL_SCLK: assert property (@(posedge clk) disable iff (!rst_n)
    (pend && !rx_rd) |=> (pend && !sclk_q)); // R6
  AST_TXRX_BLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && (cfg_mode == M_TXRX) && rx_full_q) |=> !busy); // R7
  AST_TX_ONLY_NO_RX: assert property (@(posedge clk) disable iff (!rst_n)
    (!rx_full_q && !cap_q) |=> !rx_full_q); // R8
  AST_SCLK_IDLE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !sclk_q); // R10
  AST_CS_TAIL: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(busy) && !cfg_en) |=> !cs_n); // R12
endmodule

// File: tb/spi_rx_chan_tb_top.sv
module spi_rx_chan_tb_top;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic        rst_n, cfg_en, cfg_turbo, tx_wr, rx_rd;
  logic [1:0]  cfg_mode;
  logic [4:0]  cfg_wlen;
  logic [3:0]  cfg_div;
  logic [31:0] tx_data, rx_data;
  logic        tx_empty, rx_full, eot, sclk, mosi, cs_n;

  int checks = 0, errors = 0, rises = 0, mosi_bad = 0, mcnt = 0, bw = 8, sb = 7;
  longint cyc = 0;
  logic [31:0] sw = '0, mw = '0, last_rd = '0;
  logic [31:0] slave_q[$], exp_q[$], mexp_q[$], got_q[$];
  string cur_req = "R2";

  wire miso = sw[sb];

  spi_rx_chan #(.WMAX(32), .DIVW(4)) dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_en(cfg_en), .cfg_mode(cfg_mode),
    .cfg_turbo(cfg_turbo), .cfg_wlen(cfg_wlen), .cfg_div(cfg_div),
    .tx_wr(tx_wr), .tx_data(tx_data), .tx_empty(tx_empty), .rx_rd(rx_rd),
    .rx_data(rx_data), .rx_full(rx_full), .eot(eot), .sclk(sclk),
    .mosi(mosi), .miso(miso), .cs_n(cs_n));

  function automatic logic [31:0] bmask(input int b);
    return (b >= 32) ? 32'hFFFF_FFFF : ((32'd1 << b) - 32'd1);
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic wrap_up;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  always @(posedge clk) cyc <= cyc + 1;

  // slave model: next bit presented after each falling SCLK edge
  always @(negedge sclk) begin
    if (sb == 0) begin
      sw = (slave_q.size() != 0) ? slave_q.pop_front() : 32'h0;
      sb = bw - 1;
    end else begin
      sb = sb - 1;
    end
  end

  // MOSI monitor and pulse counter
  always @(posedge sclk) begin
    logic [31:0] e;
    rises++;
    if (cfg_mode == 2'b01 && mosi) mosi_bad++;
    mw = {mw[30:0], mosi};
    mcnt++;
    if (mcnt == bw) begin
      mcnt = 0;
      if (mexp_q.size() != 0) begin
        e = mexp_q.pop_front();
        chk((mw & bmask(bw)) == e, cur_req, "mosi word", mw & bmask(bw), e);
      end
    end
  end

  // receive scoreboard
  always @(negedge clk) begin
    logic [31:0] g, e;
    if (got_q.size() != 0) begin
      g = got_q.pop_front();
      if (exp_q.size() == 0) chk(1'b0, cur_req, "unexpected rx word", g, 0);
      else begin
        e = exp_q.pop_front();
        chk(g == e, cur_req, "rx word", g, e);
      end
    end
  end

  task automatic setcfg(input logic [1:0] m, input logic t, input logic [4:0] wf,
                        input int bits, input logic [3:0] d, input string req);
    @(negedge clk);
    cfg_mode = m; cfg_turbo = t; cfg_wlen = wf; cfg_div = d;
    bw = bits; rises = 0; mcnt = 0; mosi_bad = 0; cur_req = req;
  endtask

  task automatic slave_add(input logic [31:0] w, input bit expect_rx);
    slave_q.push_back(w);
    if (expect_rx) exp_q.push_back(w & bmask(bw));
  endtask

  task automatic slave_arm;
    sw = slave_q.pop_front();
    sb = bw - 1;
  endtask

  task automatic host_read;
    @(negedge clk);
    rx_rd = 1'b1;
    last_rd = rx_data;
    got_q.push_back(rx_data);
    @(negedge clk);
    rx_rd = 1'b0;
  endtask

  task automatic tx_write(input logic [31:0] w);
    @(negedge clk);
    tx_wr = 1'b1; tx_data = w;
    @(negedge clk);
    tx_wr = 1'b0;
  endtask

  task automatic wait_full;
    while (!rx_full) @(negedge clk);
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic measure_period(output longint p);
    longint t1;
    @(posedge sclk) t1 = cyc;
    @(posedge sclk) p = cyc - t1;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    chk(1'b0, "ALL", "watchdog expired", 0, 1);
    wrap_up;
  end

  initial begin
    longint p;
    int cnt;
    rst_n = 1'b0; cfg_en = 1'b0; cfg_mode = 2'b00; cfg_turbo = 1'b0;
    cfg_wlen = 5'd7; cfg_div = 4'd1; tx_wr = 1'b0; rx_rd = 1'b0; tx_data = '0;
    idle(5);
    // R1 reset state
    chk(cs_n == 1'b1, "R1", "cs_n", cs_n, 1);
    chk(sclk == 1'b0, "R1", "sclk", sclk, 0);
    chk(mosi == 1'b0, "R1", "mosi", mosi, 0);
    chk(rx_full == 1'b0, "R1", "rx_full", rx_full, 0);
    chk(tx_empty == 1'b1, "R1", "tx_empty", tx_empty, 1);
    chk(eot == 1'b1, "R1", "eot", eot, 1);
    rst_n = 1'b1;
    idle(3);

    // R2 transmit-receive, two words
    setcfg(2'b00, 1'b0, 5'd7, 8, 4'd1, "R2");
    slave_add(32'hA5, 1); slave_add(32'h3C, 1); slave_arm;
    mexp_q.push_back(32'h5A); mexp_q.push_back(32'hC3);
    cfg_en = 1'b1;
    tx_write(32'h5A);
    measure_period(p);
    chk(p == 2, "R10", "sclk period div1", p, 2);
    wait_full; host_read;
    tx_write(32'hC3);
    wait_full; host_read;
    cfg_en = 1'b0;
    idle(20);
    chk(rises == 16, "R2", "sclk pulses", rises, 16);

    // R7 turbo bit ignored in transmit-receive
    setcfg(2'b00, 1'b1, 5'd7, 8, 4'd1, "R7");
    slave_add(32'h11, 1); slave_add(32'h22, 1); slave_arm;
    mexp_q.push_back(32'h11); mexp_q.push_back(32'h77);
    cfg_en = 1'b1;
    tx_write(32'h11);
    wait_full;
    tx_write(32'h77);
    idle(100);
    chk(tx_empty == 1'b0, "R7", "second word held back", tx_empty, 0);
    chk(rises == 8, "R7", "no overlap pulses", rises, 8);
    host_read;
    wait_full; host_read;
    cfg_en = 1'b0;
    idle(20);

    // R3 receive-only without turbo, three words
    setcfg(2'b01, 1'b0, 5'd7, 8, 4'd1, "R3");
    slave_add(32'h81, 1); slave_add(32'h42, 1); slave_add(32'hE7, 1); slave_arm;
    cfg_en = 1'b1;
    for (int k = 0; k < 3; k++) begin
      wait_full;
      if (k == 0) begin
        idle(60);
        chk(rises == 8, "R3", "no start while full", rises, 8);
        chk(eot == 1'b1, "R13", "eot idle rx-only", eot, 1);
      end
      if (k == 2) cfg_en = 1'b0;
      host_read;
    end
    idle(100);
    chk(rises == 24, "R3", "no extra word", rises, 24);
    chk(rx_full == 1'b0, "R3", "rx_full after last read", rx_full, 0);
    chk(mosi_bad == 0, "R11", "mosi high in rx-only", mosi_bad, 0);

    // R4 R5 R6 R12 receive-only turbo burst of four words
    setcfg(2'b01, 1'b1, 5'd7, 8, 4'd2, "R4");
    slave_add(32'h12, 1); slave_add(32'h34, 1); slave_add(32'h56, 1); slave_add(32'h78, 1);
    slave_arm;
    cfg_en = 1'b1;
    wait_full;
    chk(cs_n == 1'b0, "R12", "cs_n asserted", cs_n, 0);
    idle(100);
    chk(rises == 16, "R4", "second word overlapped", rises, 16);
    chk(rx_full == 1'b1, "R6", "rx_full while stalled", rx_full, 1);
    chk(eot == 1'b0, "R13", "eot with pending word", eot, 0);
    chk(sclk == 1'b0, "R6", "sclk stalled low", sclk, 0);
    host_read;
    chk(rx_full == 1'b1, "R4", "full after pending move", rx_full, 1);
    host_read;
    wait_full;
    idle(4);
    cfg_en = 1'b0;
    cur_req = "R5";
    host_read;
    wait_full;
    cnt = 0;
    while (!cs_n) begin @(negedge clk); cnt++; end
    chk(cnt == 4, "R12", "cs_n release delay", cnt, 4);
    chk(rises == 32, "R5", "in-flight word finished", rises, 32);
    host_read;
    idle(100);
    chk(rises == 32, "R5", "no word after disable", rises, 32);
    chk(rx_full == 1'b0, "R5", "rx_full drained", rx_full, 0);
    chk(mosi_bad == 0, "R11", "mosi high in turbo", mosi_bad, 0);

    // R8 R13 R10 transmit-only
    setcfg(2'b10, 1'b1, 5'd7, 8, 4'd3, "R8");
    slave_add(32'hFF, 0); slave_arm;
    mexp_q.push_back(32'hC9);
    cfg_en = 1'b1;
    tx_write(32'hC9);
    measure_period(p);
    chk(p == 8, "R10", "sclk period div3", p, 8);
    chk(eot == 1'b0, "R13", "eot during word", eot, 0);
    while (!eot) @(negedge clk);
    chk(rx_full == 1'b0, "R8", "rx_full in tx-only", rx_full, 0);
    chk(tx_empty == 1'b1, "R13", "tx_empty at eot", tx_empty, 1);
    chk(rises == 8, "R8", "sclk pulses", rises, 8);
    cfg_en = 1'b0;
    idle(60);

    // R9 word lengths 32, 4 and clamped
    setcfg(2'b01, 1'b0, 5'd31, 32, 4'd0, "R9");
    slave_add(32'hDEADBEEF, 1); slave_arm;
    cfg_en = 1'b1;
    measure_period(p);
    chk(p == 2, "R10", "sclk period div0", p, 2);
    wait_full; cfg_en = 1'b0; host_read;
    chk(last_rd == 32'hDEADBEEF, "R9", "32-bit word", last_rd, 32'hDEADBEEF);
    idle(20);

    setcfg(2'b01, 1'b0, 5'd3, 4, 4'd1, "R9");
    slave_add(32'hFFFF_FFFB, 1); slave_arm;
    cfg_en = 1'b1;
    wait_full; cfg_en = 1'b0; host_read;
    chk(last_rd == 32'hB, "R9", "4-bit right aligned", last_rd, 32'hB);
    idle(20);
    chk(rises == 4, "R9", "4-bit pulses", rises, 4);

    setcfg(2'b01, 1'b0, 5'd1, 4, 4'd1, "R9");
    slave_add(32'h6, 1); slave_arm;
    cfg_en = 1'b1;
    wait_full; cfg_en = 1'b0; host_read;
    idle(20);
    chk(rises == 4, "R9", "clamped length pulses", rises, 4);
    chk(last_rd == 32'h6, "R9", "clamped word", last_rd, 32'h6);

    idle(5);
    chk(exp_q.size() == 0, "R2", "rx words outstanding", exp_q.size(), 0);
    chk(mexp_q.size() == 0, "R2", "mosi words outstanding", mexp_q.size(), 0);
    wrap_up;
  end
endmodule